// File: doc/BRIEF.md
# Five-Bank LED Scan Controller

This block time-multiplexes a common-cathode LED display of five banks. Software, or a serial front end, holds a 24-bit display word and an 8-bit configuration word in registers and pulses a load strobe whenever either one changes. The controller then turns the five bank enables on one at a time. While a bank is on, its 4-bit nibble from the display word is decoded into seven segment enables plus a decimal-point enable. Each bank can use hexadecimal digits, a fixed set of letters and symbols, or raw bits for discrete lamps.

The scan rate comes from the system clock frequency and a target refresh rate, which are both parameters. A short all-off gap at the start of every bank slot prevents ghosting. A dim setting halves the segment on-time inside each slot. A low-power setting blanks the whole display and parks the scan. Every load blanks the display for a fixed interval and then restarts the scan at bank 1.

Top module: `led_scan_ctrl`

## Requirements
- R1: Slot k (k = 0..4) drives bank_o bit k. At most one bank_o bit is high at a time. Slots follow one another in the order 0,1,2,3,4,0,… and each slot lasts SLOT_CYC = CLK_HZ/(REFRESH_HZ*5) clock cycles (40 with the defaults).
- R2: For the first GAP_CYC cycles of every slot, all banks are off. The bank is then on for the remaining SLOT_CYC-GAP_CYC cycles (2 and 38 with the defaults).
- R3: The bank of slot k shows display bits [4k+3:4k], with bit 4k as the least significant bit of its nibble.
- R4: In hex mode seg_o[6:0] (bit 0 = a … bit 6 = g) gives these patterns for nibble values 0..F: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R5: The mode of slot k is set by config bit k+1. A low bit selects hex mode. A high bit defers to config bit 6 for slots 0–2 and to config bit 7 for slots 3–4: that bit selects glyph mode when high and raw mode when low.
- R6: In raw mode seg_o[3:0] equals the nibble and seg_o[6:4] is 0.
- R7: In glyph mode seg_o[6:0] gives these patterns for nibble values 0..F: 00 58 76 74 1E 38 54 5C 73 50 3E 1C 6E 40 48 63.
- R8: seg_o[7], the decimal point, is set by display bits [22:20] in every mode. Code 0 lights no slot, codes 1..5 light slot code-1 only, code 6 lights slots 0 and 1, and code 7 lights every slot.
- R9: bright_o follows display bit 23. When that bit is high, the segments stay on for the whole on-window of a bank. When it is low, the segments are on only for the first (SLOT_CYC-GAP_CYC)/2 cycles of the on-window (19 with the defaults).
- R10: While config bit 0 is low, bank_o and seg_o are 0. When that bit goes high with no load, the bank of slot 0 turns on GAP_CYC clock edges later.
- R11: A load pulse sampled at a clock edge keeps bank_o at 0 for BLANK_CYC+GAP_CYC cycles. The bank of slot 0 then turns on at the next edge.
- R12: seg_o is never nonzero while bank_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_word | input | 24 | Display register: five nibbles, decimal-point code, brightness bit |
| cfg_word | input | 8 | Configuration register: run bit, per-bank mode bits, two group bits |
| load | input | 1 | One-cycle strobe marking a register write |
| seg_o | output | 8 | Segment enables a..g in bits 0..6, decimal point in bit 7 |
| bank_o | output | 5 | One-hot bank (common cathode) enables |
| bright_o | output | 1 | High for full brightness |

## Verification
A load pulse set up before clock edge E0 keeps the banks dark after edges E0 through E0+BLANK_CYC+GAP_CYC-1. Bank 1 is first visible after edge E0+BLANK_CYC+GAP_CYC, and leaving low-power mode shows bank 1 after GAP_CYC edges. The bench samples at falling edges and counts exactly those edges before each comparison. After each load, the driver queues the five expected bank windows in scan order. The monitor takes one item off the queue each time a window opens. It checks the bank and the segment pattern in the first on cycle, the window length when the bank drops, the number of cycles with segments lit (full or half window), and the dark gap before each window.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

   localparam int unsigned NIB_W = 4;
   localparam int unsigned SEG_W = 8;

   typedef enum logic [1:0] {
      DM_HEX   = 2'd0,
      DM_RAW   = 2'd1,
      DM_GLYPH = 2'd2
   } dec_mode_t;

   // seven-segment numerals and letters, bit 0 = a ... bit 6 = g
   function automatic logic [6:0] hex_glyph(input logic [NIB_W-1:0] v);
      logic [6:0] s;
      unique case (v)
         4'h0: s = 7'h3F;
         4'h1: s = 7'h06;
         4'h2: s = 7'h5B;
         4'h3: s = 7'h4F;
         4'h4: s = 7'h66;
         4'h5: s = 7'h6D;
         4'h6: s = 7'h7D;
         4'h7: s = 7'h07;
         4'h8: s = 7'h7F;
         4'h9: s = 7'h6F;
         4'hA: s = 7'h77;
         4'hB: s = 7'h7C;
         4'hC: s = 7'h39;
         4'hD: s = 7'h5E;
         4'hE: s = 7'h79;
         default: s = 7'h71;
      endcase
      return s;
   endfunction

   // letters and symbols: blank c H h J L n o P r U u y - = degree
   function automatic logic [6:0] alt_glyph(input logic [NIB_W-1:0] v);
      logic [6:0] s;
      unique case (v)
         4'h0: s = 7'h00;
         4'h1: s = 7'h58;
         4'h2: s = 7'h76;
         4'h3: s = 7'h74;
         4'h4: s = 7'h1E;
         4'h5: s = 7'h38;
         4'h6: s = 7'h54;
         4'h7: s = 7'h5C;
         4'h8: s = 7'h73;
         4'h9: s = 7'h50;
         4'hA: s = 7'h3E;
         4'hB: s = 7'h1C;
         4'hC: s = 7'h6E;
         4'hD: s = 7'h40;
         4'hE: s = 7'h48;
         default: s = 7'h63;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
   import led_scan_pkg::*;
(
   input  logic [NIB_W-1:0] nib_i,
   input  dec_mode_t        mode_i,
   input  logic             dp_i,
   output logic [SEG_W-1:0] seg_o
);

   always_comb begin
      unique case (mode_i)
         DM_HEX:   seg_o[6:0] = hex_glyph(nib_i);
         DM_RAW:   seg_o[6:0] = {3'b000, nib_i};
         default:  seg_o[6:0] = alt_glyph(nib_i);
      endcase
      seg_o[7] = dp_i;
   end

endmodule

// File: rtl/lsc_timer.sv
module lsc_timer #(
   parameter int unsigned SLOT_CYC  = 40,
   parameter int unsigned BLANK_CYC = 12,
   parameter int unsigned BANKS     = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic                        run_i,
   output logic [$clog2(BANKS)-1:0]    idx_o,
   output logic [$clog2(SLOT_CYC)-1:0] phase_o,
   output logic                        blank_o
);

   localparam int unsigned IDX_W = $clog2(BANKS);
   localparam int unsigned PH_W  = $clog2(SLOT_CYC);
   localparam int unsigned BLK_W = $clog2(BLANK_CYC + 1);
   localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(SLOT_CYC - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANKS - 1);

   logic [BLK_W-1:0] blank_q;
   logic [IDX_W-1:0] idx_q;
   logic [PH_W-1:0]  ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_q <= '0;
         idx_q   <= '0;
         ph_q    <= '0;
      end else if (load_i) begin
         blank_q <= BLK_W'(BLANK_CYC);
         idx_q   <= '0;
         ph_q    <= '0;
      end else if (blank_q != '0) begin
         blank_q <= blank_q - 1'b1;
      end else if (!run_i) begin
         idx_q <= '0;
         ph_q  <= '0;
      end else if (ph_q == LAST_PH) begin
         ph_q  <= '0;
         idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign idx_o   = idx_q;
   assign phase_o = ph_q;
   assign blank_o = (blank_q != '0);

   // R1: a slot ends after its last phase and hands over to the next bank in order
   p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && blank_q == '0 && run_i && ph_q == LAST_PH) |=>
         (ph_q == '0 && idx_q == (($past(idx_q) == LAST_IDX) ? IDX_W'(0)
                                                             : IDX_W'($past(idx_q) + 1'b1))));

   // R10: with the run bit low the scan is parked at slot 0, phase 0
   p_sleep_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && blank_q == '0 && !run_i) |=> (ph_q == '0 && idx_q == '0));

endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
   import led_scan_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 200_000,
   parameter int unsigned REFRESH_HZ = 1_000,
   parameter int unsigned GAP_CYC    = 2,
   parameter int unsigned BLANK_CYC  = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [23:0] disp_word,
   input  logic [7:0]  cfg_word,
   input  logic        load,
   output logic [7:0]  seg_o,
   output logic [4:0]  bank_o,
   output logic        bright_o
);

   localparam int unsigned BANKS    = 5;
   localparam int unsigned SLOT_CYC = CLK_HZ / (REFRESH_HZ * BANKS);
   localparam int unsigned ON_CYC   = SLOT_CYC - GAP_CYC;
   localparam int unsigned HALF_CYC = ON_CYC / 2;
   localparam int unsigned IDX_W    = $clog2(BANKS);
   localparam int unsigned PH_W     = $clog2(SLOT_CYC);
   localparam int unsigned GRP_SPLIT = 3;   // slots below this use group bit 6

   if (SLOT_CYC < 4) begin : g_bad_slot
      $error("slot length below 4 cycles: raise CLK_HZ or lower REFRESH_HZ");
   end
   if (GAP_CYC < 1 || 2 * GAP_CYC >= SLOT_CYC) begin : g_bad_gap
      $error("GAP_CYC must be at least 1 and under half a slot");
   end
   if (BLANK_CYC < 1) begin : g_bad_blank
      $error("BLANK_CYC must be at least 1");
   end

   logic [IDX_W-1:0] idx;
   logic [PH_W-1:0]  phase;
   logic             blanking;
   logic             run;
   logic [2:0]       dp_code;

   assign run     = cfg_word[0];
   assign dp_code = disp_word[22:20];

   lsc_timer #(
      .SLOT_CYC (SLOT_CYC),
      .BLANK_CYC(BLANK_CYC),
      .BANKS    (BANKS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .run_i  (run),
      .idx_o  (idx),
      .phase_o(phase),
      .blank_o(blanking)
   );

   dec_mode_t        mode_b [BANKS];
   logic [SEG_W-1:0] seg_b  [BANKS];

   for (genvar k = 0; k < BANKS; k++) begin : g_bank
      logic grp_bit;
      logic dp_hit;

      assign grp_bit = (k < GRP_SPLIT) ? cfg_word[6] : cfg_word[7];

      always_comb begin
         if (!cfg_word[k+1])  mode_b[k] = DM_HEX;
         else if (grp_bit)    mode_b[k] = DM_GLYPH;
         else                 mode_b[k] = DM_RAW;
      end

      always_comb begin
         dp_hit = (dp_code == 3'(k + 1)) || (dp_code == 3'd7) ||
                  ((dp_code == 3'd6) && (k < 2));
      end

      lsc_decode u_dec (
         .nib_i (disp_word[NIB_W*k +: NIB_W]),
         .mode_i(mode_b[k]),
         .dp_i  (dp_hit),
         .seg_o (seg_b[k])
      );
   end

   logic bank_on;
   logic seg_gate;
   logic [SEG_W-1:0] seg_pick;

   always_comb begin
      bank_on  = run && !blanking && (phase >= PH_W'(GAP_CYC));
      seg_gate = bank_on && (disp_word[23] || (phase < PH_W'(GAP_CYC + HALF_CYC)));
      seg_pick = (idx < IDX_W'(BANKS)) ? seg_b[idx] : '0;
   end

   assign bank_o   = bank_on ? (BANKS'(1) << idx) : '0;
   assign seg_o    = seg_gate ? seg_pick : '0;
   assign bright_o = disp_word[23];

   // R1: never more than one bank enabled
   p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_o));

   // R12: segment drive only while some bank sinks it
   p_seg_needs_bank_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_o != '0) |-> (bank_o != '0));

   // R11: the cycle after a load is dark
   p_load_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bank_o == '0));

   // R6: raw-mode slots never light e, f or g
   p_raw_efg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_o != '0 && mode_b[idx] == DM_RAW) |-> (seg_o[6:4] == 3'b000));

endmodule

// File: tb/led_scan_ctrl_test.sv
module led_scan_ctrl_test;

   localparam int CLK_PER = 10;
   localparam int SLOT    = 200_000 / (1_000 * 5);
   localparam int GAP     = 2;
   localparam int BLANK   = 12;
   localparam int ON      = SLOT - GAP;
   localparam int HALF    = ON / 2;

   typedef struct packed {
      logic [2:0] bank;
      logic [7:0] seg;
      logic [7:0] dur;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] disp_word = '0;
   logic [7:0]  cfg_word = '0;
   logic        load = 1'b0;
   logic [7:0]  seg_o;
   logic [4:0]  bank_o;
   logic        bright_o;

   int n_checks = 0;
   int n_errors = 0;
   int pending  = 0;
   item_t q[$];

   always #(CLK_PER/2) clk = ~clk;

   led_scan_ctrl uut (
      .clk(clk), .rst_n(rst_n), .disp_word(disp_word), .cfg_word(cfg_word),
      .load(load), .seg_o(seg_o), .bank_o(bank_o), .bright_o(bright_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] ref_hex(input logic [3:0] v);
      logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
      return t[v];
   endfunction

   function automatic logic [6:0] ref_glyph(input logic [3:0] v);
      logic [6:0] t [16] = '{7'h00, 7'h58, 7'h76, 7'h74, 7'h1E, 7'h38, 7'h54, 7'h5C,
                             7'h73, 7'h50, 7'h3E, 7'h1C, 7'h6E, 7'h40, 7'h48, 7'h63};
      return t[v];
   endfunction

   // expected pattern from R3 to R8
   function automatic logic [7:0] ref_seg(input int k, input logic [23:0] d,
                                          input logic [7:0] c);
      logic [3:0] nib;
      logic [2:0] sel;
      logic       dp;
      logic       grp;
      logic [6:0] s;
      nib = d[4*k +: 4];
      sel = d[22:20];
      dp  = (int'(sel) == k + 1) || (sel == 3'd7) || (sel == 3'd6 && k < 2);
      grp = (k < 3) ? c[6] : c[7];
      if (!c[k+1])  s = ref_hex(nib);
      else if (grp) s = ref_glyph(nib);
      else          s = {3'b000, nib};
      return {dp, s};
   endfunction

   // monitor: pops one item per opened bank window
   item_t cur;
   bit    trk = 1'b0;
   int    win_len = 0;
   int    lit_cnt = 0;
   int    zrun = 0;
   logic [4:0] prev_bank = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bank_o != '0 && prev_bank == '0 && q.size() > 0) begin
            cur = q.pop_front();
            trk = 1'b1;
            win_len = 0;
            lit_cnt = 0;
            check(bank_o == (5'd1 << cur.bank), "R1", "bank order", bank_o, 5'd1 << cur.bank);
            check(seg_o == cur.seg, "R3/R4/R5/R6/R7/R8", "segment pattern", seg_o, cur.seg);
            if (cur.bank != 0)
               check(zrun == GAP, "R2", "dark gap before window", zrun, GAP);
         end
         if (trk) begin
            if (bank_o != '0) begin
               win_len++;
               if (seg_o != '0) lit_cnt++;
            end else begin
               check(win_len == ON, "R2", "on-window length", win_len, ON);
               check(lit_cnt == int'(cur.dur), "R9", "lit cycles", lit_cnt, cur.dur);
               trk = 1'b0;
               pending--;
            end
         end
         zrun = (bank_o == '0) ? zrun + 1 : 0;
         prev_bank = bank_o;
      end
   end

   task automatic show(input logic [23:0] d, input logic [7:0] c);
      int bad;
      @(negedge clk);
      disp_word = d;
      cfg_word  = c;
      load      = 1'b1;
      @(negedge clk);
      load = 1'b0;
      if (c[0]) begin
         for (int k = 0; k < 5; k++) begin
            item_t it;
            it.bank = 3'(k);
            it.seg  = ref_seg(k, d, c);
            it.dur  = (it.seg == '0) ? 8'd0 : (d[23] ? 8'(ON) : 8'(HALF));
            q.push_back(it);
            pending++;
         end
      end
      bad = 0;
      for (int i = 0; i < BLANK + GAP; i++) begin
         if (i > 0) @(negedge clk);
         if (bank_o != '0 || seg_o != '0) bad++;
      end
      check(bad == 0, "R11", "dark cycles after load", bad, 0);
      @(negedge clk);
      check(bank_o == (c[0] ? 5'b00001 : 5'b00000), "R11", "first bank after blanking",
            bank_o, c[0] ? 1 : 0);
      while (pending != 0) @(negedge clk);
      check(bright_o == d[23], "R9", "brightness flag", bright_o, d[23]);
   endtask

   initial begin
      repeat (100_000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL R1 watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int bad;
      repeat (3) @(negedge clk);
      check(bank_o == '0 && seg_o == '0, "R10", "reset state dark", {seg_o, bank_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(bank_o == '0, "R10", "run bit low after reset", bank_o, 0);

      show(24'h843210, 8'h01);   // hex digits, bright, no decimal point
      show(24'h7FEDCB, 8'h01);   // hex letters, dim, decimal point everywhere
      show(24'hE7A9F2, 8'h57);   // mixed modes, decimal point on slots 0 and 1
      show(24'hBC05F0, 8'h3F);   // all raw, decimal point on slot 2
      show(24'h543210, 8'hFF);   // glyphs, dim, decimal point on slot 4
      show(24'h9CBA98, 8'hFF);   // glyphs, decimal point on slot 0
      show(24'h45EDED, 8'hFF);   // glyphs, dim, decimal point on slot 3
      show(24'h298765, 8'h01);   // hex, dim, decimal point on slot 1

      // R10: low power keeps everything dark
      show(24'hFFFFFF, 8'h00);
      bad = 0;
      for (int i = 0; i < 3 * 5 * SLOT; i++) begin
         @(negedge clk);
         if (bank_o != '0 || seg_o != '0) bad++;
      end
      check(bad == 0, "R10", "low-power dark cycles", bad, 0);

      // R10: waking without a load starts at slot 0 after GAP edges
      cfg_word = 8'h01;
      bad = 0;
      for (int i = 0; i < GAP - 1; i++) begin
         @(negedge clk);
         if (bank_o != '0) bad++;
      end
      @(negedge clk);
      check(bad == 0 && bank_o == 5'b00001, "R10", "wake-up bank", bank_o, 1);

      show(24'hA01234, 8'h01);   // load in mid-scan after wake-up

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule